// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps wall-clock time (seconds, minutes, hours, day of week, day of month, month and two-digit year) in byte registers. A small register port with a 4-bit index reaches them. A one-cycle pulse on `tick_1s` starts an update cycle. The update-in-progress flag rises first and stays high for a parameterised lead window. Then one carry-chained increment is applied, covering month lengths and leap years. The new time is compared with three alarm bytes, and the flag drops one cycle later.

Values are held either in BCD or in plain binary, and hours in 24-hour or 12-hour form; two control bits select these. A freeze bit in the control register stops new updates, so software can load a consistent time. Each update produces a one-cycle `upd_done` pulse. When seconds, minutes and hours all match their alarm bytes after an update, a coincident `alarm_hit` pulse is also produced. A separate interrupt block consumes both pulses.

Top module: `tod_clock`

## Requirements
- R1: Register index 0 is seconds, 1 is seconds-alarm, 2 is minutes, 3 is minutes-alarm, 4 is hours, 5 is hours-alarm, 6 is day-of-week, 7 is day-of-month, 8 is month and 9 is year.
  - Index 11 is the control byte. Only bit 7 (freeze), bit 2 (binary) and bit 1 (24-hour) are stored; its other bits read 0.
  - Index 10 reads the update flag in bit 7 and 0 elsewhere. Index 13 always reads 0x80. Indices 12, 14 and 15 read 0.
  - `bus_rdata` is combinational from `bus_addr`. A write happens on the clock edge where `bus_en` and `bus_we` are both 1.
- R2: An update adds one second with carry. Seconds wrap from 59 to 0 and carry into minutes, and minutes wrap from 59 to 0 and carry into hours.
- R3: A day carry (24-hour mode: from 23 to 0) does three things:
  - Day-of-week counts 7 to 1.
  - Day-of-month wraps to 1 after the month's last day. April, June, September and November have 30 days. February has 29 days when year mod 4 is 0, else 28. Other months have 31 days.
  - Month wraps from 12 to 1 with a year carry, and year wraps from 99 to 0.
- R4: Let edge k be the clock edge that samples `tick_1s`=1 while idle and unfrozen.
  - `uip` is 1 from edge k.
  - The time registers change at edge k+LEAD_CYC+1.
  - `uip` returns to 0 at edge k+LEAD_CYC+2.
- R5: `upd_done` is 1 for exactly the one cycle after the time registers change, which is the last cycle of `uip`.
- R6: `alarm_hit` pulses together with `upd_done` when each of seconds, minutes and hours either equals its alarm byte or has an alarm byte with bits 7 and 6 both 1 (wildcard).
- R7: While control bit 7 is 1, `tick_1s` starts no update. Register writes still take effect on the next edge.
- R8: With control bit 2 = 1 all time fields count in binary. With 0 they count in BCD.
- R9: With control bit 1 = 0 the hours byte holds 1..12, with bit 7 = PM. 11 AM goes to 12 PM, 12 goes to 1 with PM kept, and 11 PM goes to 12 AM, which advances the date.
- R10: While `uip` is 1, writes to time indices (0, 2, 4, 6, 7, 8, 9) are dropped and further ticks are ignored.
- R11: After reset the time is 00:00:00, day-of-week 1, date 1/1/00, alarms 0, control 0x02 (24-hour BCD), `uip` 0 and no pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| bus_en | input | 1 | Register access enable |
| bus_we | input | 1 | Write strobe, qualified by bus_en |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| uip | output | 1 | Update-in-progress flag |
| upd_done | output | 1 | One-cycle update-ended pulse |
| alarm_hit | output | 1 | One-cycle alarm-match pulse |

## Verification
The hardest case to reach is a register write or second tick landing inside the short update window. This window is only LEAD_CYC+2 cycles wide and opens a fixed number of cycles after a tick. The bench drives that case by counting falling edges after its own tick: it places a seconds write and a second tick at known cycle offsets within the window, then confirms that exactly one increment was applied. Calendar corners are set up by loading boundary times under freeze and then releasing it. These corners are leap and non-leap February, a 30-day month, year 99 and 11 PM in 12-hour mode.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int IX_SEC    = 0;
    localparam int IX_SEC_AL = 1;
    localparam int IX_MIN    = 2;
    localparam int IX_MIN_AL = 3;
    localparam int IX_HR     = 4;
    localparam int IX_HR_AL  = 5;
    localparam int IX_DOW    = 6;
    localparam int IX_DOM    = 7;
    localparam int IX_MON    = 8;
    localparam int IX_YR     = 9;
    localparam int IX_STAT   = 10;
    localparam int IX_CTRL   = 11;
    localparam int IX_VALID  = 13;
    localparam int NREG      = 10;

    localparam int CB_FREEZE = 7;
    localparam int CB_BIN    = 2;
    localparam int CB_H24    = 1;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_COMMIT,
        SQ_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] dow;
        logic [7:0] dom;
        logic [7:0] mon;
        logic [7:0] yr;
    } tod_t;

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] t;
        logic [7:0] o;
        t = v / 8'd10;
        o = v - (t * 8'd10);
        return (t << 4) | o;
    endfunction

    function automatic logic [7:0] to_num(input logic [7:0] raw, input logic bin);
        return bin ? raw : bcd_to_bin(raw);
    endfunction

    function automatic logic [7:0] from_num(input logic [7:0] v, input logic bin);
        return bin ? v : bin_to_bcd(v);
    endfunction

endpackage

// File: rtl/tod_incr.sv
module tod_incr
    import tod_pkg::*;
(
    input  tod_t cur,
    input  logic bin,
    input  logic h24,
    output tod_t nxt
);

    logic [7:0] s_d, m_d, h_d, dw_d, dd_d, mo_d, y_d, mlen, h_enc;
    logic       pm_d, c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        s_d  = to_num(cur.sec, bin);
        m_d  = to_num(cur.min, bin);
        y_d  = to_num(cur.yr, bin);
        mo_d = to_num(cur.mon, bin);
        dd_d = to_num(cur.dom, bin);
        dw_d = cur.dow;
        pm_d = 1'b0;
        if (h24) begin
            h_d = to_num(cur.hr, bin);
        end else begin
            pm_d = cur.hr[7];
            h_d  = to_num({1'b0, cur.hr[6:0]}, bin);
        end

        c_min = (s_d >= 8'd59);
        s_d   = c_min ? 8'd0 : s_d + 8'd1;

        c_hr = 1'b0;
        if (c_min) begin
            c_hr = (m_d >= 8'd59);
            m_d  = c_hr ? 8'd0 : m_d + 8'd1;
        end

        c_day = 1'b0;
        if (c_hr) begin
            if (h24) begin
                c_day = (h_d >= 8'd23);
                h_d   = c_day ? 8'd0 : h_d + 8'd1;
            end else if (h_d == 8'd11) begin
                h_d   = 8'd12;
                c_day = pm_d;
                pm_d  = ~pm_d;
            end else if (h_d >= 8'd12) begin
                h_d = 8'd1;
            end else begin
                h_d = h_d + 8'd1;
            end
        end

        case (mo_d)
            8'd2:                      mlen = (y_d[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   mlen = 8'd30;
            default:                   mlen = 8'd31;
        endcase

        c_mon = 1'b0;
        c_yr  = 1'b0;
        if (c_day) begin
            dw_d  = (dw_d >= 8'd7) ? 8'd1 : dw_d + 8'd1;
            c_mon = (dd_d >= mlen);
            dd_d  = c_mon ? 8'd1 : dd_d + 8'd1;
        end
        if (c_mon) begin
            c_yr = (mo_d >= 8'd12);
            mo_d = c_yr ? 8'd1 : mo_d + 8'd1;
        end
        if (c_yr) begin
            y_d = (y_d >= 8'd99) ? 8'd0 : y_d + 8'd1;
        end

        h_enc   = from_num(h_d, bin);
        nxt.sec = from_num(s_d, bin);
        nxt.min = from_num(m_d, bin);
        nxt.hr  = h24 ? h_enc : {pm_d, h_enc[6:0]};
        nxt.dow = dw_d;
        nxt.dom = from_num(dd_d, bin);
        nxt.mon = from_num(mo_d, bin);
        nxt.yr  = from_num(y_d, bin);
    end

endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp #(
    parameter int NF = 3,
    parameter int FW = 8
) (
    input  logic [NF*FW-1:0] now_v,
    input  logic [NF*FW-1:0] alm_v,
    output logic             hit
);

    logic [NF-1:0] field_ok;

    for (genvar i = 0; i < NF; i++) begin : g_field
        logic [FW-1:0] a_f;
        logic [FW-1:0] n_f;
        assign a_f = alm_v[i*FW +: FW];
        assign n_f = now_v[i*FW +: FW];
        assign field_ok[i] = (a_f[FW-1 -: 2] == 2'b11) || (a_f == n_f);
    end

    assign hit = &field_ok;

endmodule

// File: rtl/tod_seq.sv
module tod_seq
    import tod_pkg::*;
#(
    parameter int LEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    output logic busy,
    output logic commit,
    output logic finish
);

    localparam int CW = $clog2(LEAD_CYC + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        case (q_q.st)
            SQ_IDLE: begin
                if (tick && !hold) begin
                    q_d.st  = SQ_LEAD;
                    q_d.cnt = '0;
                end
            end
            SQ_LEAD: begin
                if (q_q.cnt == CW'(LEAD_CYC - 1)) q_d.st = SQ_COMMIT;
                else                              q_d.cnt = q_q.cnt + 1'b1;
            end
            SQ_COMMIT: q_d.st = SQ_FINISH;
            default:   q_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: SQ_IDLE, cnt: '0};
        else        q_q <= q_d;
    end

    assign busy   = (q_q.st != SQ_IDLE);
    assign commit = (q_q.st == SQ_COMMIT);
    assign finish = (q_q.st == SQ_FINISH);

    // R4: the commit cycle is always preceded by the lead window
    a_r4_lead_before_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit) |-> $past(q_q.st == SQ_LEAD));

    // R5: the update-ended cycle is the last busy cycle
    a_r5_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int LEAD_CYC = 8,
    parameter int AW       = 4,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1s,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          uip,
    output logic          upd_done,
    output logic          alarm_hit
);

    localparam int NAL = 3;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] rg;
        logic                    frz;
        logic                    bin;
        logic                    h24;
    } regs_t;

    regs_t st_q, st_d;

    logic busy, commit, finish, match, wr;
    tod_t cur_t, nxt_t;

    assign wr = bus_en && bus_we;

    tod_seq #(.LEAD_CYC(LEAD_CYC)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1s),
        .hold   (st_q.frz),
        .busy   (busy),
        .commit (commit),
        .finish (finish)
    );

    assign cur_t = '{sec: st_q.rg[IX_SEC], min: st_q.rg[IX_MIN], hr: st_q.rg[IX_HR],
                     dow: st_q.rg[IX_DOW], dom: st_q.rg[IX_DOM], mon: st_q.rg[IX_MON],
                     yr: st_q.rg[IX_YR]};

    tod_incr u_incr (
        .cur (cur_t),
        .bin (st_q.bin),
        .h24 (st_q.h24),
        .nxt (nxt_t)
    );

    tod_alarm_cmp #(.NF(NAL), .FW(DW)) u_cmp (
        .now_v ({st_q.rg[IX_HR], st_q.rg[IX_MIN], st_q.rg[IX_SEC]}),
        .alm_v ({st_q.rg[IX_HR_AL], st_q.rg[IX_MIN_AL], st_q.rg[IX_SEC_AL]}),
        .hit   (match)
    );

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.rg[IX_SEC] = nxt_t.sec;
            st_d.rg[IX_MIN] = nxt_t.min;
            st_d.rg[IX_HR]  = nxt_t.hr;
            st_d.rg[IX_DOW] = nxt_t.dow;
            st_d.rg[IX_DOM] = nxt_t.dom;
            st_d.rg[IX_MON] = nxt_t.mon;
            st_d.rg[IX_YR]  = nxt_t.yr;
        end
        if (wr) begin
            case (int'(bus_addr))
                IX_SEC_AL, IX_MIN_AL, IX_HR_AL:
                    st_d.rg[bus_addr] = bus_wdata;
                IX_SEC, IX_MIN, IX_HR, IX_DOW, IX_DOM, IX_MON, IX_YR:
                    if (!busy) st_d.rg[bus_addr] = bus_wdata;
                IX_CTRL: begin
                    st_d.frz = bus_wdata[CB_FREEZE];
                    st_d.bin = bus_wdata[CB_BIN];
                    st_d.h24 = bus_wdata[CB_H24];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.rg[IX_DOW]  <= 8'd1;
            st_q.rg[IX_DOM]  <= 8'd1;
            st_q.rg[IX_MON]  <= 8'd1;
            st_q.h24         <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            IX_STAT:  bus_rdata[DW-1] = busy;
            IX_CTRL:  begin
                bus_rdata[CB_FREEZE] = st_q.frz;
                bus_rdata[CB_BIN]    = st_q.bin;
                bus_rdata[CB_H24]    = st_q.h24;
            end
            IX_VALID: bus_rdata[DW-1] = 1'b1;
            default:  if (int'(bus_addr) < NREG) bus_rdata = st_q.rg[bus_addr];
        endcase
    end

    assign uip       = busy;
    assign upd_done  = finish;
    assign alarm_hit = finish && match;

    // R4: seconds never change by an update unless the flag was high
    a_r4_uip_before_change: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (st_q.rg[IX_SEC] != $past(st_q.rg[IX_SEC]))
         && !$past(wr && bus_addr == AW'(IX_SEC))) |-> $past(uip));

    // R6: alarm pulse only accompanies an update-ended pulse
    a_r6_alarm_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_done);

    // R7: frozen and idle with no write: seconds hold
    a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st_q.frz && !wr && !busy)) |->
        (st_q.rg[IX_SEC] == $past(st_q.rg[IX_SEC])));

    // R10: busy and not committing: seconds hold whatever is written
    a_r10_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(busy && !commit)) |->
        (st_q.rg[IX_SEC] == $past(st_q.rg[IX_SEC])));

endmodule

// File: tb/sim_tod_clock.sv
module sim_tod_clock;

    localparam int LEAD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       uip, upd_done, alarm_hit;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    tod_clock #(.LEAD_CYC(LEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, int'(bus_rdata), int'(exp));
    endtask

    task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr_reg(4'd4, h);
        wr_reg(4'd2, m);
        wr_reg(4'd0, s);
    endtask

    task automatic run_tick(output int dn, output int al);
        dn = 0; al = 0;
        @(negedge clk); tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
        for (int i = 0; i < LEAD + 4; i++) begin
            if (upd_done)  dn++;
            if (alarm_hit) al++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rd_chk("R11 sec", 4'd0, 8'h00);
        rd_chk("R11 hr", 4'd4, 8'h00);
        rd_chk("R11 dow", 4'd6, 8'h01);
        rd_chk("R11 dom", 4'd7, 8'h01);
        rd_chk("R11 mon", 4'd8, 8'h01);
        rd_chk("R11 yr", 4'd9, 8'h00);
        rd_chk("R11 alarm", 4'd5, 8'h00);
        rd_chk("R11 ctrl", 4'd11, 8'h02);
        rd_chk("R11 status", 4'd10, 8'h00);
        chk("R11 pulses", int'({uip, upd_done, alarm_hit}), 0);
        rd_chk("R1 valid", 4'd13, 8'h80);
        rd_chk("R1 idx12", 4'd12, 8'h00);
    endtask

    task automatic t_regmap;
        wr_reg(4'd1, 8'h12); wr_reg(4'd3, 8'h34); wr_reg(4'd5, 8'h56);
        rd_chk("R1 sec alarm", 4'd1, 8'h12);
        rd_chk("R1 min alarm", 4'd3, 8'h34);
        rd_chk("R1 hr alarm", 4'd5, 8'h56);
        wr_reg(4'd11, 8'hFF);
        rd_chk("R1 ctrl bits", 4'd11, 8'h86);
        wr_reg(4'd11, 8'h02);
    endtask

    task automatic t_timing;
        int dn_at, seen;
        set_hms(8'h09, 8'h59, 8'h59);
        dn_at = -1; seen = 0;
        bus_addr = 4'd0;
        @(negedge clk); tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
        for (int i = 0; i <= LEAD + 2; i++) begin
            if (i == 0) begin
                chk("R4 uip rises", int'(uip), 1);
                bus_addr = 4'd10; #1;
                chk("R1 status bit7", int'(bus_rdata), 8'h80);
                bus_addr = 4'd0; #1;
            end
            if (i == LEAD) begin
                chk("R4 sec not yet", int'(bus_rdata), 8'h59);
                chk("R4 uip held", int'(uip), 1);
            end
            if (i == LEAD + 1) begin
                chk("R4 sec changed", int'(bus_rdata), 8'h00);
                chk("R5 done with uip", int'(uip), 1);
            end
            if (i == LEAD + 2) chk("R4 uip falls", int'(uip), 0);
            if (upd_done) begin dn_at = i; seen++; end
            @(negedge clk);
        end
        chk("R5 done cycle", dn_at, LEAD + 1);
        chk("R5 done width", seen, 1);
        rd_chk("R2 min carry", 4'd2, 8'h00);
        rd_chk("R2 hr carry", 4'd4, 8'h10);
    endtask

    task automatic t_freeze;
        int dn, al;
        wr_reg(4'd11, 8'h82);
        wr_reg(4'd0, 8'h33);
        rd_chk("R7 write immediate", 4'd0, 8'h33);
        run_tick(dn, al);
        rd_chk("R7 frozen sec", 4'd0, 8'h33);
        chk("R7 no update", dn, 0);
        wr_reg(4'd11, 8'h02);
        run_tick(dn, al);
        rd_chk("R7 resumes", 4'd0, 8'h34);
    endtask

    task automatic load_date(input logic [7:0] dw, input logic [7:0] dd,
                             input logic [7:0] mo, input logic [7:0] yr);
        wr_reg(4'd11, 8'h82);
        set_hms(8'h23, 8'h59, 8'h59);
        wr_reg(4'd6, dw); wr_reg(4'd7, dd); wr_reg(4'd8, mo); wr_reg(4'd9, yr);
        wr_reg(4'd11, 8'h02);
    endtask

    task automatic t_calendar;
        int dn, al;
        load_date(8'h07, 8'h28, 8'h02, 8'h24);
        run_tick(dn, al);
        rd_chk("R3 leap dom", 4'd7, 8'h29);
        rd_chk("R3 leap mon", 4'd8, 8'h02);
        rd_chk("R3 dow wrap", 4'd6, 8'h01);
        rd_chk("R3 hr wrap", 4'd4, 8'h00);
        load_date(8'h03, 8'h28, 8'h02, 8'h23);
        run_tick(dn, al);
        rd_chk("R3 nonleap dom", 4'd7, 8'h01);
        rd_chk("R3 nonleap mon", 4'd8, 8'h03);
        rd_chk("R3 dow step", 4'd6, 8'h04);
        load_date(8'h01, 8'h30, 8'h04, 8'h10);
        run_tick(dn, al);
        rd_chk("R3 30-day dom", 4'd7, 8'h01);
        rd_chk("R3 30-day mon", 4'd8, 8'h05);
        load_date(8'h05, 8'h31, 8'h12, 8'h99);
        run_tick(dn, al);
        rd_chk("R3 year dom", 4'd7, 8'h01);
        rd_chk("R3 year mon", 4'd8, 8'h01);
        rd_chk("R3 year wrap", 4'd9, 8'h00);
    endtask

    task automatic t_binary;
        int dn, al;
        wr_reg(4'd11, 8'h86);
        set_hms(8'd22, 8'd59, 8'd59);
        wr_reg(4'd11, 8'h06);
        run_tick(dn, al);
        rd_chk("R8 bin sec", 4'd0, 8'd0);
        rd_chk("R8 bin min", 4'd2, 8'd0);
        rd_chk("R8 bin hr", 4'd4, 8'd23);
        wr_reg(4'd0, 8'd9);
        run_tick(dn, al);
        rd_chk("R8 bin 9 to 10", 4'd0, 8'd10);
        wr_reg(4'd11, 8'h02);
    endtask

    task automatic t_12h;
        int dn, al;
        wr_reg(4'd11, 8'h80);
        set_hms(8'h11, 8'h59, 8'h59);
        wr_reg(4'd11, 8'h00);
        run_tick(dn, al);
        rd_chk("R9 11AM to 12PM", 4'd4, 8'h92);
        set_hms(8'h92, 8'h59, 8'h59);
        run_tick(dn, al);
        rd_chk("R9 12PM to 1PM", 4'd4, 8'h81);
        set_hms(8'h91, 8'h59, 8'h59);
        wr_reg(4'd7, 8'h05);
        run_tick(dn, al);
        rd_chk("R9 11PM to 12AM", 4'd4, 8'h12);
        rd_chk("R9 date advances", 4'd7, 8'h06);
        wr_reg(4'd11, 8'h02);
    endtask

    task automatic t_alarm;
        int dn, al;
        set_hms(8'h10, 8'h20, 8'h29);
        wr_reg(4'd1, 8'h30); wr_reg(4'd3, 8'h20); wr_reg(4'd5, 8'h10);
        run_tick(dn, al);
        chk("R6 exact match", al, 1);
        chk("R5 one done", dn, 1);
        run_tick(dn, al);
        chk("R6 mismatch silent", al, 0);
        wr_reg(4'd1, 8'hC5); wr_reg(4'd3, 8'hFF); wr_reg(4'd5, 8'hC0);
        run_tick(dn, al);
        chk("R6 wildcard match", al, 1);
        wr_reg(4'd1, 8'h80); wr_reg(4'd0, 8'h7F);
        run_tick(dn, al);
        chk("R6 one top bit not wild", al, 0);
    endtask

    task automatic t_busy;
        int dn;
        dn = 0;
        set_hms(8'h05, 8'h05, 8'h10);
        @(negedge clk); tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 8'h44;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
        for (int i = 0; i < 3 * LEAD; i++) begin
            if (upd_done) dn++;
            @(negedge clk);
        end
        rd_chk("R10 write dropped, one step", 4'd0, 8'h11);
        chk("R10 tick ignored", dn, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_timing;
        t_freeze;
        t_calendar;
        t_binary;
        t_12h;
        t_alarm;
        t_busy;
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule